// File: doc/BRIEF.md
# Writeback Slot Allocator

This block places finished instructions into a short, time-indexed writeback window that feeds the commit stage. The window is a set of future cycles, called rows. Each row has one slot per writeback port. Every cycle, up to `LANES` completion requests arrive, and each carries an instruction tag. The allocator puts each tag in the first free slot, searching row by row. When the nearest row is full, the tag spills into a later row, so the request is served without a stall.

The search always starts again at row 0, slot 0 in every cycle. Nothing about where the previous search stopped is kept. When `advance_i` is raised, the head row goes out toward commit with a valid mask, a tag per slot and an occupancy count. The remaining rows move one step closer, and an empty row enters at the far end. A request that finds no free slot anywhere in the window is dropped and flagged.

Top module: `wb_slot_alloc`

## Requirements
- R1: After synchronous reset, `wb_valid_o`, `wb_mask_o`, `wb_count_o`, `wb_tags_o` and `overflow_o` are all zero, and every slot of the window is free.
- R2: Slots are ordered by flat index row*SLOTS+slot. The search raises the slot index and wraps to slot 0 of the next row at SLOTS. Lanes are served lowest index first: lane 0 takes the first free slot, and the next valid lane takes the next free slot after it.
- R3: When the rows closer to the head are full, a request is placed in the first free slot of a later row, up to row ROWS-1. It is not stalled.
- R4: Each cycle's search starts again at row 0, slot 0. A slot left free in an earlier row is taken before any slot in a later row, whatever was allocated in the previous cycle.
- R5: Each row keeps an occupancy count that rises by one for each tag placed in it. `wb_count_o` equals the number of set bits in `wb_mask_o` whenever `wb_valid_o` is high.
- R6: Raising `advance_i` in a cycle makes `wb_valid_o` high in the next cycle. The emitted head row includes tags allocated into row 0 in the same cycle. Row r+1 becomes row r, and the last row becomes empty. The tag of slot s is at `wb_tags_o[s*TAG_W +: TAG_W]`.
- R7: A valid lane that finds no free slot in any row is dropped and leaves the window unchanged. `overflow_o[lane]` is high in the next cycle. A later valid lane is also dropped whenever an earlier lane is dropped.
- R8: While `advance_i` is low, `wb_mask_o`, `wb_tags_o` and `wb_count_o` keep their values, and `wb_valid_o` is low.
- R9: A lane with `req_valid_i` low takes no slot, so the next valid lane gets the slot that the idle lane would have taken. The tag of lane l is at `req_tag_i[l*TAG_W +: TAG_W]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid_i | input | LANES | Per-lane completion request |
| req_tag_i | input | LANES*TAG_W | Per-lane instruction tag, lane 0 in the low bits |
| advance_i | input | 1 | Emit the head row and move the window by one cycle |
| wb_valid_o | output | 1 | Head row emitted this cycle |
| wb_mask_o | output | SLOTS | Occupied slots of the emitted row |
| wb_tags_o | output | SLOTS*TAG_W | Tags of the emitted row, slot 0 in the low bits |
| wb_count_o | output | CNT_W | Occupancy count of the emitted row |
| overflow_o | output | LANES | Per-lane drop flag for a full window |

## Verification
The assertions check on every cycle these rules:
- the emitted count agrees with the emitted mask;
- an emission pulse follows every advance;
- the outputs hold between advances;
- a drop only ever follows a valid request;
- a later lane is never served after an earlier lane was dropped.

The cases below need the bench's reference model and its directed scenarios, which compare every output on every clock:
- where each tag lands;
- the spill into later rows;
- the restart of the search at row 0;
- the treatment of idle lanes;
- tags that are allocated and emitted in the same cycle.

// File: rtl/wbs_pkg.sv
package wbs_pkg;

    localparam int unsigned DEF_ROWS  = 5;
    localparam int unsigned DEF_SLOTS = 4;
    localparam int unsigned DEF_LANES = 2;
    localparam int unsigned DEF_TAG_W = 8;

    // Width of a counter that must hold the values 0..n
    function automatic int unsigned count_width(input int unsigned n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction

    // Per-lane search result
    typedef enum logic [1:0] {
        LANE_IDLE   = 2'd0,
        LANE_PLACED = 2'd1,
        LANE_DROPPED = 2'd2
    } lane_state_e;

endpackage

// File: rtl/wbs_finder.sv
module wbs_finder #(
    parameter int unsigned N     = 20,
    parameter int unsigned LANES = 2
) (
    input  logic [N-1:0]            occ_i,
    input  logic [LANES-1:0]        want_i,
    output logic [LANES-1:0][N-1:0] pick_o,
    output logic [LANES-1:0]        miss_o
);
    import wbs_pkg::*;

    logic [N-1:0]                taken;
    logic                        found;
    lane_state_e [LANES-1:0]     state;

    // Lanes in ascending order; each one claims the lowest free slot left
    always_comb begin
        taken  = occ_i;
        pick_o = '0;
        state  = '{default: LANE_IDLE};
        for (int l = 0; l < LANES; l++) begin
            found = 1'b0;
            if (want_i[l]) begin
                for (int i = 0; i < N; i++) begin
                    if (!found && !taken[i]) begin
                        pick_o[l][i] = 1'b1;
                        found        = 1'b1;
                    end
                end
                state[l] = found ? LANE_PLACED : LANE_DROPPED;
            end
            taken = taken | pick_o[l];
        end
    end

    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            miss_o[l] = (state[l] == LANE_DROPPED);
        end
    end

endmodule

// File: rtl/wbs_row.sv
module wbs_row #(
    parameter int unsigned SLOTS = 4,
    parameter int unsigned TAG_W = 8,
    parameter int unsigned LANES = 2,
    parameter int unsigned CNT_W = 3
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              advance_i,
    input  logic [LANES-1:0][SLOTS-1:0]       pick_i,
    input  logic [LANES-1:0][TAG_W-1:0]       tag_i,
    input  logic [SLOTS-1:0]                  up_mask_i,
    input  logic [SLOTS-1:0][TAG_W-1:0]       up_tags_i,
    input  logic [CNT_W-1:0]                  up_cnt_i,
    output logic [SLOTS-1:0]                  occ_o,
    output logic [SLOTS-1:0]                  mrg_mask_o,
    output logic [SLOTS-1:0][TAG_W-1:0]       mrg_tags_o,
    output logic [CNT_W-1:0]                  mrg_cnt_o
);
    logic [SLOTS-1:0]            mask_q;
    logic [SLOTS-1:0][TAG_W-1:0] tags_q;
    logic [CNT_W-1:0]            cnt_q;

    assign occ_o = mask_q;

    // Merge this cycle's placements into the stored row
    always_comb begin
        mrg_mask_o = mask_q;
        mrg_tags_o = tags_q;
        mrg_cnt_o  = cnt_q;
        for (int l = 0; l < LANES; l++) begin
            if (|pick_i[l]) begin
                mrg_cnt_o = mrg_cnt_o + CNT_W'(1);
            end
            for (int s = 0; s < SLOTS; s++) begin
                if (pick_i[l][s]) begin
                    mrg_mask_o[s] = 1'b1;
                    mrg_tags_o[s] = tag_i[l];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            tags_q <= '0;
            cnt_q  <= '0;
        end else if (advance_i) begin
            mask_q <= up_mask_i;
            tags_q <= up_tags_i;
            cnt_q  <= up_cnt_i;
        end else begin
            mask_q <= mrg_mask_o;
            tags_q <= mrg_tags_o;
            cnt_q  <= mrg_cnt_o;
        end
    end

endmodule

// File: rtl/wb_slot_alloc.sv
module wb_slot_alloc #(
    parameter int unsigned ROWS  = wbs_pkg::DEF_ROWS,
    parameter int unsigned SLOTS = wbs_pkg::DEF_SLOTS,
    parameter int unsigned LANES = wbs_pkg::DEF_LANES,
    parameter int unsigned TAG_W = wbs_pkg::DEF_TAG_W,
    localparam int unsigned CNT_W = wbs_pkg::count_width(SLOTS)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [LANES-1:0]         req_valid_i,
    input  logic [LANES*TAG_W-1:0]   req_tag_i,
    input  logic                     advance_i,
    output logic                     wb_valid_o,
    output logic [SLOTS-1:0]         wb_mask_o,
    output logic [SLOTS*TAG_W-1:0]   wb_tags_o,
    output logic [CNT_W-1:0]         wb_count_o,
    output logic [LANES-1:0]         overflow_o
);
    localparam int unsigned N = ROWS * SLOTS;

    logic [LANES-1:0][TAG_W-1:0]          lane_tag;
    logic [ROWS-1:0][SLOTS-1:0]           occ;
    logic [N-1:0]                         occ_flat;
    logic [LANES-1:0][N-1:0]              pick;
    logic [LANES-1:0]                     miss;
    logic [ROWS-1:0][LANES-1:0][SLOTS-1:0] row_pick;
    logic [ROWS-1:0][SLOTS-1:0]           m_mask;
    logic [ROWS-1:0][SLOTS-1:0][TAG_W-1:0] m_tags;
    logic [ROWS-1:0][CNT_W-1:0]           m_cnt;

    assign lane_tag = req_tag_i;
    assign occ_flat = occ;

    wbs_finder #(.N(N), .LANES(LANES)) u_find (
        .occ_i  (occ_flat),
        .want_i (req_valid_i),
        .pick_o (pick),
        .miss_o (miss)
    );

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic [SLOTS-1:0]            up_mask;
        logic [SLOTS-1:0][TAG_W-1:0] up_tags;
        logic [CNT_W-1:0]            up_cnt;

        for (genvar l = 0; l < LANES; l++) begin : g_lane
            assign row_pick[r][l] = pick[l][r*SLOTS +: SLOTS];
        end

        if (r == ROWS - 1) begin : g_tail
            assign up_mask = '0;
            assign up_tags = '0;
            assign up_cnt  = '0;
        end else begin : g_mid
            assign up_mask = m_mask[r+1];
            assign up_tags = m_tags[r+1];
            assign up_cnt  = m_cnt[r+1];
        end

        wbs_row #(.SLOTS(SLOTS), .TAG_W(TAG_W), .LANES(LANES), .CNT_W(CNT_W)) u_row (
            .clk        (clk),
            .rst        (rst),
            .advance_i  (advance_i),
            .pick_i     (row_pick[r]),
            .tag_i      (lane_tag),
            .up_mask_i  (up_mask),
            .up_tags_i  (up_tags),
            .up_cnt_i   (up_cnt),
            .occ_o      (occ[r]),
            .mrg_mask_o (m_mask[r]),
            .mrg_tags_o (m_tags[r]),
            .mrg_cnt_o  (m_cnt[r])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wb_valid_o <= 1'b0;
            wb_mask_o  <= '0;
            wb_tags_o  <= '0;
            wb_count_o <= '0;
            overflow_o <= '0;
        end else begin
            wb_valid_o <= advance_i;
            overflow_o <= miss;
            if (advance_i) begin
                wb_mask_o  <= m_mask[0];
                wb_tags_o  <= m_tags[0];
                wb_count_o <= m_cnt[0];
            end
        end
    end

endmodule

// File: rtl/wbs_checker.sv
module wbs_checker #(
    parameter int unsigned SLOTS = 4,
    parameter int unsigned LANES = 2,
    parameter int unsigned CNT_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic [LANES-1:0] req_valid_i,
    input logic             advance_i,
    input logic             wb_valid_o,
    input logic [SLOTS-1:0] wb_mask_o,
    input logic [CNT_W-1:0] wb_count_o,
    input logic [LANES-1:0] overflow_o
);
    // R5
    count_mask_chk: assert property (@(posedge clk) disable iff (rst)
        wb_valid_o |-> (32'(wb_count_o) == $countones(wb_mask_o)));

    // R6
    emit_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (wb_valid_o == $past(advance_i)));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(advance_i)) |-> ($stable(wb_mask_o) && $stable(wb_count_o)));

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        // R7
        drop_req_chk: assert property (@(posedge clk) disable iff (rst)
            overflow_o[l] |-> (!$past(rst) && $past(req_valid_i[l])));
        if (l > 0) begin : g_ord
            // R7
            drop_order_chk: assert property (@(posedge clk) disable iff (rst)
                (overflow_o[l-1] && $past(req_valid_i[l])) |-> overflow_o[l]);
        end
    end

endmodule

bind wb_slot_alloc wbs_checker #(.SLOTS(SLOTS), .LANES(LANES), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid_i (req_valid_i),
    .advance_i   (advance_i),
    .wb_valid_o  (wb_valid_o),
    .wb_mask_o   (wb_mask_o),
    .wb_count_o  (wb_count_o),
    .overflow_o  (overflow_o)
);

// File: tb/test_wb_slot_alloc.sv
module test_wb_slot_alloc;
    localparam int ROWS = 5, SLOTS = 4, LANES = 2, TAG_W = 8, CNT_W = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [LANES-1:0] req_valid_i = '0;
    logic [LANES*TAG_W-1:0] req_tag_i = '0;
    logic advance_i = 1'b0;
    logic wb_valid_o;
    logic [SLOTS-1:0] wb_mask_o;
    logic [SLOTS*TAG_W-1:0] wb_tags_o;
    logic [CNT_W-1:0] wb_count_o;
    logic [LANES-1:0] overflow_o;

    always #5 clk = ~clk;

    wb_slot_alloc i_wb_slot_alloc (
        .clk(clk), .rst(rst), .req_valid_i(req_valid_i), .req_tag_i(req_tag_i),
        .advance_i(advance_i), .wb_valid_o(wb_valid_o), .wb_mask_o(wb_mask_o),
        .wb_tags_o(wb_tags_o), .wb_count_o(wb_count_o), .overflow_o(overflow_o)
    );

    // Behavioural reference: the window as plain integer arrays
    int m_occ [ROWS][SLOTS];
    int m_tag [ROWS][SLOTS];
    int m_cnt [ROWS];
    int e_valid, e_mask, e_cnt;
    int e_tag [SLOTS];
    int e_ovf [LANES];
    int checks = 0, failures = 0;
    bit done = 0;

    task automatic check(input string rq, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int r = 0; r < ROWS; r++) begin
            m_cnt[r] = 0;
            for (int s = 0; s < SLOTS; s++) begin m_occ[r][s] = 0; m_tag[r][s] = 0; end
        end
        e_valid = 0; e_mask = 0; e_cnt = 0;
        for (int s = 0; s < SLOTS; s++) e_tag[s] = 0;
        for (int l = 0; l < LANES; l++) e_ovf[l] = 0;
    endtask

    task automatic compare(input string rq);
        check(rq, "wb_valid", int'(wb_valid_o), e_valid);
        check(rq, "wb_mask", int'(wb_mask_o), e_mask);
        check(rq, "wb_count", int'(wb_count_o), e_cnt);
        for (int l = 0; l < LANES; l++) check(rq, "overflow", int'(overflow_o[l]), e_ovf[l]);
        for (int s = 0; s < SLOTS; s++)
            if (e_mask[s]) check(rq, "wb_tag", int'(wb_tags_o[s*TAG_W +: TAG_W]), e_tag[s]);
    endtask

    task automatic step(input logic [1:0] v, input int t0, input int t1, input logic adv, input string rq);
        int tg [LANES];
        @(negedge clk);
        req_valid_i = v;
        req_tag_i = {TAG_W'(t1), TAG_W'(t0)};
        advance_i = adv;
        tg[0] = t0 & 8'hFF; tg[1] = t1 & 8'hFF;
        for (int l = 0; l < LANES; l++) begin
            e_ovf[l] = 0;
            if (v[l]) begin
                int r = 0, s = 0;
                while (r < ROWS && m_occ[r][s] != 0) begin
                    s++;
                    if (s == SLOTS) begin s = 0; r++; end
                end
                if (r == ROWS) e_ovf[l] = 1;
                else begin m_occ[r][s] = 1; m_tag[r][s] = tg[l]; m_cnt[r]++; end
            end
        end
        e_valid = adv;
        if (adv) begin
            e_mask = 0;
            for (int s = 0; s < SLOTS; s++) begin
                if (m_occ[0][s] != 0) e_mask |= (1 << s);
                e_tag[s] = m_tag[0][s];
            end
            e_cnt = m_cnt[0];
            for (int r = 0; r < ROWS - 1; r++) begin
                m_cnt[r] = m_cnt[r+1];
                for (int s = 0; s < SLOTS; s++) begin
                    m_occ[r][s] = m_occ[r+1][s]; m_tag[r][s] = m_tag[r+1][s];
                end
            end
            m_cnt[ROWS-1] = 0;
            for (int s = 0; s < SLOTS; s++) begin m_occ[ROWS-1][s] = 0; m_tag[ROWS-1][s] = 0; end
        end
        @(posedge clk);
        #1;
        compare(rq);
    endtask

    initial begin
        model_clear();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        #1;
        compare("R1");
        step(2'b00, 0, 0, 1'b1, "R1");               // empty head row
        // R2: lane order and row-major placement
        step(2'b11, 8'h11, 8'h12, 1'b0, "R2");
        step(2'b01, 8'h13, 0, 1'b1, "R2");
        // R3 and R5: spill across rows without advancing
        for (int i = 0; i < 6; i++) step(2'b11, 8'h20 + 2*i, 8'h21 + 2*i, 1'b0, "R3");
        for (int i = 0; i < 4; i++) step(2'b00, 0, 0, 1'b1, "R5");
        // R9: idle lane 0, lane 1 takes slot 0
        step(2'b10, 0, 8'h40, 1'b0, "R9");
        step(2'b10, 0, 8'h41, 1'b1, "R9");
        // R4: after a shift, the search restarts at row 0
        for (int i = 0; i < 3; i++) step(2'b11, 8'h50 + 2*i, 8'h51 + 2*i, 1'b0, "R4");
        step(2'b00, 0, 0, 1'b1, "R4");
        step(2'b01, 8'h60, 0, 1'b0, "R4");
        // R6: allocation into row 0 in the same cycle as the advance
        step(2'b11, 8'h61, 8'h62, 1'b1, "R6");
        // R8: outputs hold with no advance
        step(2'b00, 0, 0, 1'b0, "R8");
        step(2'b01, 8'h63, 0, 1'b0, "R8");
        // R7: fill the whole window, then overflow
        for (int i = 0; i < 12; i++) step(2'b11, 8'h80 + 2*i, 8'h81 + 2*i, 1'b0, "R7");
        step(2'b10, 0, 8'hA0, 1'b0, "R7");
        step(2'b11, 8'hA1, 8'hA2, 1'b1, "R7");
        step(2'b11, 8'hA3, 8'hA4, 1'b0, "R7");
        for (int i = 0; i < 6; i++) step(2'b00, 0, 0, 1'b1, "R6");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule